// File: doc/BRIEF.md
# 20-bit Operand Address Generator

This block forms the 20-bit effective address of one instruction operand. The operand is either a source or a destination. It takes the addressing-mode bits, the register number and its contents, and the address of the operand's index word. It also takes the 16-bit index word, a 4-bit index extension and a flag that says whether the instruction uses the extended encoding. From these it forms the address and raises a flag when the operand is an immediate, a register, or a constant taken from a generator register. The logic is purely combinational, so the result is ready in the same cycle as the inputs.

Two rules exist for forming an indexed address. Under the legacy rule, a base below 64 KB keeps the result inside the low 64 KB. A base at or above 64 KB receives a sign-extended 16-bit index. Under the extended rule, the 4-bit extension is placed above the index word to make a signed 20-bit index. The block has no handshake: a decode stage drives the inputs and samples the outputs in the same cycle.

Top module: `oper_addr_gen`

## Requirements
- R1: A source operand with `mode_bits`=00 and any register except R3 raises `reg_direct`, drives `eff_addr` to zero and keeps the other two flags low.
- R2: A source operand using R3 in any mode, or R2 with `mode_bits`=10 or 11, raises `const_gen`, drives `eff_addr` to zero and keeps the other two flags low.
- R3: In indexed mode (`mode_bits`=01), the base is `pc_val` for R0 (symbolic), zero for R2 (absolute) and `reg_val` for every other register.
- R4: Under the legacy rule (`ext_fmt`=0), an indexed base whose bits 19:16 are zero yields the low 16 bits of base plus index, with bits 19:16 cleared (0x00200 with 0xFFD0 gives 0x001D0).
- R5: Under the legacy rule, an indexed base of 0x10000 or above yields the base plus the sign-extended index, modulo 2^20 (0x101D0 with 0xFFD0 gives 0x101A0).
- R6: Under the extended rule (`ext_fmt`=1), the index is {`idx_ext`,`idx_word`} taken as a signed 20-bit value and added to the base modulo 2^20. Under the legacy rule, `idx_ext` has no effect.
- R7: A source operand in indirect mode (10) or auto-increment mode (11) that is not a constant yields its base register (`pc_val` for R0) as the address, and the index inputs have no effect.
- R8: A source operand with `mode_bits`=11 on R0 raises `imm_op`, and `eff_addr` equals `pc_val`.
- R9: For a destination (`is_dst`=1), only `mode_bits[0]` is decoded. A value of 0 gives a register operand and 1 gives an indexed operand. `mode_bits[1]` has no effect, and `const_gen` never rises.
- R10: At most one of `imm_op`, `reg_direct` and `const_gen` is high for any input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| is_dst | input | 1 | 1: destination operand, 0: source operand |
| mode_bits | input | 2 | Addressing mode: 00 register, 01 indexed, 10 indirect, 11 auto-increment |
| reg_sel | input | 4 | Register number of the operand |
| reg_val | input | 20 | Contents of the selected register |
| pc_val | input | 20 | Address of the operand's index word (base for R0) |
| idx_word | input | 16 | Index word that follows the instruction |
| idx_ext | input | 4 | Upper index bits from the extension word |
| ext_fmt | input | 1 | 1: extended rule, 0: legacy rule |
| eff_addr | output | 20 | Effective operand address, zero when no memory operand |
| imm_op | output | 1 | Operand is an immediate located at `pc_val` |
| reg_direct | output | 1 | Operand is the register itself |
| const_gen | output | 1 | Operand comes from a constant generator register |

## Verification
The hardest cases to reach are the wrap cases at the edges of the address space. One is a legacy base just below 64 KB whose sum carries past bit 15 and must be dropped. Another is a base near 0xFFFFF that wraps past the top of the 20-bit space. The third is a negative extended index that carries below address zero. The sweep crosses bases 0x0FFF0 and 0xFFFF8 with the indices 0x7FFF, 0x8000 and 0xFFD0 and extension nibbles 0x0, 0x7 and 0xF. It applies each combination to every register, mode, operand side and rule, so each carry boundary is crossed under both rules. Directed vectors repeat the worked address examples.

// File: rtl/oag_pkg.sv
package oag_pkg;

  typedef enum logic [1:0] {
    MD_REG = 2'b00,
    MD_IDX = 2'b01,
    MD_IND = 2'b10,
    MD_INC = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    BS_REG  = 2'd0,
    BS_PC   = 2'd1,
    BS_ZERO = 2'd2
  } base_e;

  typedef struct packed {
    logic  regdir;
    logic  cgen;
    logic  imm;
    logic  use_mem;
    logic  use_idx;
    base_e base;
  } dec_t;

endpackage

// File: rtl/oag_mode_dec.sv
module oag_mode_dec
  import oag_pkg::*;
#(
  parameter int REG_W   = 4,
  parameter int PC_REG  = 0,
  parameter int ABS_REG = 2,
  parameter int CG2_REG = 3
) (
  input  logic             is_dst,
  input  logic [1:0]       mode_bits,
  input  logic [REG_W-1:0] reg_sel,
  output dec_t             dec
);

  localparam logic [REG_W-1:0] PC_ID  = PC_REG[REG_W-1:0];
  localparam logic [REG_W-1:0] ABS_ID = ABS_REG[REG_W-1:0];
  localparam logic [REG_W-1:0] CG2_ID = CG2_REG[REG_W-1:0];

  mode_e eff_mode;
  logic  sel_pc;
  logic  sel_abs;
  logic  sel_cg2;

  always_comb begin
    eff_mode = is_dst ? mode_e'({1'b0, mode_bits[0]}) : mode_e'(mode_bits);
    sel_pc   = (reg_sel == PC_ID);
    sel_abs  = (reg_sel == ABS_ID);
    sel_cg2  = (reg_sel == CG2_ID);
  end

  always_comb begin
    dec      = '0;
    dec.base = BS_REG;
    if (!is_dst && (sel_cg2 || (sel_abs && eff_mode[1]))) begin
      dec.cgen = 1'b1;
    end else begin
      unique case (eff_mode)
        MD_REG: dec.regdir = 1'b1;
        MD_IDX: begin
          dec.use_mem = 1'b1;
          dec.use_idx = 1'b1;
          if (sel_pc)       dec.base = BS_PC;
          else if (sel_abs) dec.base = BS_ZERO;
          else              dec.base = BS_REG;
        end
        MD_IND, MD_INC: begin
          dec.use_mem = 1'b1;
          dec.base    = sel_pc ? BS_PC : BS_REG;
          dec.imm     = sel_pc && (eff_mode == MD_INC);
        end
        default: dec = '0;
      endcase
    end
  end

endmodule

// File: rtl/oag_index_form.sv
module oag_index_form #(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0]        idx_word,
  input  logic [ADDR_W-WORD_W-1:0] idx_ext,
  input  logic                     ext_fmt,
  output logic [ADDR_W-1:0]        idx_full
);

  localparam int EXT_W = ADDR_W - WORD_W;

  logic [EXT_W-1:0] upper;

  always_comb begin
    upper    = ext_fmt ? idx_ext : {EXT_W{idx_word[WORD_W-1]}};
    idx_full = {upper, idx_word};
  end

endmodule

// File: rtl/oag_base_sum.sv
module oag_base_sum #(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] idx_full,
  input  logic              use_idx,
  input  logic              ext_fmt,
  output logic [ADDR_W-1:0] addr
);

  localparam int EXT_W = ADDR_W - WORD_W;

  logic [ADDR_W-1:0] raw_sum;
  logic              low_window;

  always_comb begin
    raw_sum    = base + (use_idx ? idx_full : '0);
    low_window = use_idx && !ext_fmt && (base[ADDR_W-1:WORD_W] == '0);
  end

  genvar b;
  generate
    for (b = 0; b < ADDR_W; b++) begin : g_bit
      if (b < WORD_W) begin : g_low
        assign addr[b] = raw_sum[b];
      end else begin : g_high
        assign addr[b] = raw_sum[b] & ~low_window;
      end
    end
  endgenerate

endmodule

// File: rtl/oper_addr_gen.sv
module oper_addr_gen
  import oag_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 16,
  parameter int REG_N  = 16
) (
  input  logic                        is_dst,
  input  logic [1:0]                  mode_bits,
  input  logic [$clog2(REG_N)-1:0]    reg_sel,
  input  logic [ADDR_W-1:0]           reg_val,
  input  logic [ADDR_W-1:0]           pc_val,
  input  logic [WORD_W-1:0]           idx_word,
  input  logic [ADDR_W-WORD_W-1:0]    idx_ext,
  input  logic                        ext_fmt,
  output logic [ADDR_W-1:0]           eff_addr,
  output logic                        imm_op,
  output logic                        reg_direct,
  output logic                        const_gen
);

  localparam int REG_W = $clog2(REG_N);

  dec_t              dec;
  logic [ADDR_W-1:0] idx_full;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] sum_addr;

  oag_mode_dec #(.REG_W(REG_W)) u_dec (
    .is_dst   (is_dst),
    .mode_bits(mode_bits),
    .reg_sel  (reg_sel),
    .dec      (dec)
  );

  oag_index_form #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_idx (
    .idx_word(idx_word),
    .idx_ext (idx_ext),
    .ext_fmt (ext_fmt),
    .idx_full(idx_full)
  );

  always_comb begin
    unique case (dec.base)
      BS_PC:   base = pc_val;
      BS_ZERO: base = '0;
      default: base = reg_val;
    endcase
  end

  oag_base_sum #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_sum (
    .base    (base),
    .idx_full(idx_full),
    .use_idx (dec.use_idx),
    .ext_fmt (ext_fmt),
    .addr    (sum_addr)
  );

  always_comb begin
    eff_addr   = dec.use_mem ? sum_addr : '0;
    imm_op     = dec.imm;
    reg_direct = dec.regdir;
    const_gen  = dec.cgen;
  end

endmodule

// File: rtl/oag_chk.sv
module oag_chk #(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 16,
  parameter int REG_N  = 16
) (
  input logic                        is_dst,
  input logic [1:0]                  mode_bits,
  input logic [$clog2(REG_N)-1:0]    reg_sel,
  input logic [ADDR_W-1:0]           reg_val,
  input logic [ADDR_W-1:0]           pc_val,
  input logic [WORD_W-1:0]           idx_word,
  input logic [ADDR_W-WORD_W-1:0]    idx_ext,
  input logic                        ext_fmt,
  input logic [ADDR_W-1:0]           eff_addr,
  input logic                        imm_op,
  input logic                        reg_direct,
  input logic                        const_gen
);

  localparam int REG_W = $clog2(REG_N);

  logic plain_reg;
  logic src_idx;
  logic [ADDR_W-1:0] delta;

  always_comb begin
    plain_reg = (reg_sel != REG_W'(0)) && (reg_sel != REG_W'(2)) && (reg_sel != REG_W'(3));
    src_idx   = !is_dst && (mode_bits == 2'b01) && plain_reg;
    delta     = eff_addr - reg_val;

    // R10
    flags_onehot_chk: assert ($onehot0({imm_op, reg_direct, const_gen}));
    // R1
    if (reg_direct) regdir_noaddr_chk: assert (eff_addr == '0);
    // R2
    if (const_gen) cgen_noaddr_chk: assert (eff_addr == '0);
    // R8
    if (imm_op) imm_at_pc_chk: assert (eff_addr == pc_val);
    // R9
    if (is_dst) dst_no_cgen_chk: assert (!const_gen);
    // R4
    if (src_idx && !ext_fmt && (reg_val[ADDR_W-1:WORD_W] == '0))
      legacy_window_chk: assert (eff_addr[ADDR_W-1:WORD_W] == '0);
    // R6
    if (src_idx && ext_fmt)
      ext_offset_chk: assert (delta == {idx_ext, idx_word});
  end

endmodule

bind oper_addr_gen oag_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .REG_N(REG_N)) u_chk (
  .is_dst    (is_dst),
  .mode_bits (mode_bits),
  .reg_sel   (reg_sel),
  .reg_val   (reg_val),
  .pc_val    (pc_val),
  .idx_word  (idx_word),
  .idx_ext   (idx_ext),
  .ext_fmt   (ext_fmt),
  .eff_addr  (eff_addr),
  .imm_op    (imm_op),
  .reg_direct(reg_direct),
  .const_gen (const_gen)
);

// File: tb/test_oper_addr_gen.sv
module test_oper_addr_gen;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        is_dst = 1'b0;
  logic [1:0]  mode_bits = '0;
  logic [3:0]  reg_sel = '0;
  logic [19:0] reg_val = '0;
  logic [19:0] pc_val = '0;
  logic [15:0] idx_word = '0;
  logic [3:0]  idx_ext = '0;
  logic        ext_fmt = 1'b0;
  logic [19:0] eff_addr;
  logic        imm_op, reg_direct, const_gen;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oper_addr_gen i_oper_addr_gen (
    .is_dst(is_dst), .mode_bits(mode_bits), .reg_sel(reg_sel), .reg_val(reg_val),
    .pc_val(pc_val), .idx_word(idx_word), .idx_ext(idx_ext), .ext_fmt(ext_fmt),
    .eff_addr(eff_addr), .imm_op(imm_op), .reg_direct(reg_direct), .const_gen(const_gen)
  );

  task automatic check(input string tag, input logic [22:0] got, input logic [22:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got addr=%05h imm/reg/cg=%03b, expected addr=%05h imm/reg/cg=%03b",
               tag, got[19:0], got[22:20], exp[19:0], exp[22:20]);
    end
  endtask

  task automatic apply(input bit d, input logic [1:0] m, input logic [3:0] r, input logic [19:0] rv,
                       input logic [19:0] pc, input logic [15:0] iw, input logic [3:0] ie, input bit ef);
    @(posedge clk);
    is_dst = d; mode_bits = m; reg_sel = r; reg_val = rv;
    pc_val = pc; idx_word = iw; idx_ext = ie; ext_fmt = ef;
    @(negedge clk);
  endtask

  // Reference model built from the requirements with integer arithmetic.
  task automatic expect_vec(output logic [22:0] exp, output string tag);
    logic [1:0] em;
    int base, idx, sum;
    em  = is_dst ? {1'b0, mode_bits[0]} : mode_bits;
    exp = '0;
    if (!is_dst && (reg_sel == 3 || (reg_sel == 2 && em[1]))) begin
      exp[20+0] = 1'b1; tag = "R2";
    end else if (em == 2'b00) begin
      exp[20+1] = 1'b1; tag = is_dst ? "R9" : "R1";
    end else begin
      if (reg_sel == 0) base = int'(pc_val);
      else if (reg_sel == 2 && em == 2'b01) base = 0;
      else base = int'(reg_val);
      if (em == 2'b01) begin
        if (ext_fmt) begin
          idx = int'(idx_ext) * 65536 + int'(idx_word);
          if (idx >= 524288) idx -= 1048576;
          sum = (base + idx + 1048576) % 1048576;
          tag = "R6";
        end else if (base < 65536) begin
          sum = (base + int'(idx_word)) % 65536;
          tag = "R4";
        end else begin
          idx = int'(idx_word);
          if (idx >= 32768) idx -= 65536;
          sum = (base + idx + 1048576) % 1048576;
          tag = "R5";
        end
        if (is_dst) tag = "R9";
        else if (reg_sel == 0 || reg_sel == 2) tag = "R3";
      end else begin
        sum = base;
        if (reg_sel == 0 && em == 2'b11) begin
          exp[20+2] = 1'b1; tag = "R8";
        end else tag = "R7";
      end
      exp[19:0] = 20'(sum);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    logic [19:0] bases [6] = '{20'h00000, 20'h00200, 20'h0FFF0, 20'h10000, 20'h101D0, 20'hFFFF8};
    logic [19:0] pcs   [2] = '{20'h03114, 20'h1001A};
    logic [15:0] idxs  [6] = '{16'h0000, 16'h0002, 16'h7FFF, 16'h8000, 16'hFFD0, 16'h01E6};
    logic [3:0]  exts  [3] = '{4'h0, 4'hF, 4'h7};
    logic [22:0] exp;
    string tag;

    // Zero inputs: source R0 register mode -> register direct (R1)
    @(negedge clk);
    check("R1 idle", {imm_op, reg_direct, const_gen, eff_addr}, {3'b010, 20'h0});

    // Worked examples
    apply(0, 2'b01, 4'd5, 20'h00200, 20'h0, 16'hFFD0, 4'h0, 0);
    check("R4 example", {imm_op, reg_direct, const_gen, eff_addr}, {3'b000, 20'h001D0});
    apply(0, 2'b01, 4'd5, 20'h101D0, 20'h0, 16'hFFD0, 4'h0, 0);
    check("R5 example", {imm_op, reg_direct, const_gen, eff_addr}, {3'b000, 20'h101A0});
    apply(0, 2'b01, 4'd0, 20'h0, 20'h1001A, 16'h01E6, 4'h0, 0);
    check("R3 symbolic", {imm_op, reg_direct, const_gen, eff_addr}, {3'b000, 20'h10200});
    apply(0, 2'b01, 4'd0, 20'h0, 20'h03114, 16'hD0EC, 4'hF, 1);
    check("R6 example", {imm_op, reg_direct, const_gen, eff_addr}, {3'b000, 20'h00200});
    apply(1, 2'b01, 4'd2, 20'h12345, 20'h0, 16'h0202, 4'h0, 1);
    check("R3 absolute", {imm_op, reg_direct, const_gen, eff_addr}, {3'b000, 20'h00202});
    apply(0, 2'b11, 4'd0, 20'h55555, 20'h0ABCE, 16'h1234, 4'h3, 1);
    check("R8 immediate", {imm_op, reg_direct, const_gen, eff_addr}, {3'b100, 20'h0ABCE});

    // Sweep of every mode, register, side and rule
    for (int d = 0; d < 2; d++)
      for (int m = 0; m < 4; m++)
        for (int r = 0; r < 16; r++)
          for (int ef = 0; ef < 2; ef++)
            for (int bi = 0; bi < 6; bi++)
              for (int pi = 0; pi < 2; pi++)
                for (int ii = 0; ii < 6; ii++)
                  for (int ei = 0; ei < 3; ei++) begin
                    apply(d[0], m[1:0], r[3:0], bases[bi], pcs[pi], idxs[ii], exts[ei], ef[0]);
                    expect_vec(exp, tag);
                    check(tag, {imm_op, reg_direct, const_gen, eff_addr}, exp);
                    if ($countones({imm_op, reg_direct, const_gen}) > 1)
                      check("R10", 23'(1), 23'(0));
                  end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule